// File: doc/BRIEF.md
# Sparse stream register file

This block presents a large, strided, memory-mapped window with one slot per stream, but it stores only a few registers. Each of the 64 streams keeps two 32-bit tile counters. One counter counts tiles handed to a circular buffer by its producer. The other counts tiles released by its consumer. Software finds out how many tiles are ready, or how much room is free, by reading the two counters and taking their difference.

Besides the counters, the window holds one general-purpose sync register. It also holds a dispatch location whose writes are sunk, and each such write emits a one-cycle pulse.

Producers and consumers move the counters through a separate atomic-add port, so they need no read-modify-write over the bus. An init command clears the counters of the first N streams. The clear takes one cycle per stream. While it runs, the block holds off the bus and the add port with a ready signal. Bus reads return data one cycle after they are accepted. Every address that the block does not store reads as zero, and writes to such addresses are dropped silently.

Top module: `strm_regfile`

## Requirements
- R1: After reset, every counter and the sync register read 0, `clr_busy` and `dispatch_pulse` are 0, `ready` is 1, and `rd_valid` is 0.
- R2: A bus read accepted at a clock edge (`bus_valid & ready & !bus_write`) sets `rd_valid` high with its data for exactly the following cycle. `rd_valid` is low in every other cycle.
- R3: Word index 8 of stream s (byte address 0xFFB40000 + s*0x1000 + 0x20, s in 0..63) is that stream's released-tile counter. It is read/write, and each stream's counter is independent of the others.
- R4: Word index 10 of stream s (byte offset 0x28 in the stream's slot) is that stream's handed-tile counter. It is read/write and independent per stream.
- R5: Word index 31 of stream 0 (0xFFB4007C) is a read/write sync register. Index 31 of any other stream reads 0.
- R6: A bus write to 0xFFB70438 (stream 48, word index 270) raises `dispatch_pulse` for exactly the one cycle after the write is accepted. A read of that address returns 0.
- R7: Any other address reads 0, and writes to it change no stored register. This covers unmapped indices, addresses outside the 256 KiB window, and addresses with bits [1:0] non-zero.
- R8: An accepted add with `add_sel`=0 adds `add_amount` to the handed-tile counter of `add_stream`. With `add_sel`=1 it adds to the released-tile counter. The sum wraps modulo 2^32.
- R9: When a bus write and an add hit the same counter at the same edge, the add is applied to the old value and the write is dropped. When they hit different counters, both take effect.
- R10: A command with `cmd_code`=0x03 and count n clears both counters of streams 0..min(n,64)-1. All other counters and the sync register are untouched. Any other code, or n=0, has no effect.
- R11: After an accepted clear command, `clr_busy` is high and `ready` is low for exactly min(n,64) cycles. Bus and add requests made while `ready` is low are not accepted.
- R12: A bus read accepted at the same edge as an add to the same counter returns the value from before the add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| ready | output | 1 | Bus and add requests are accepted when high |
| rd_valid | output | 1 | Read data valid (one cycle after the request) |
| rd_data | output | 32 | Read data |
| add_valid | input | 1 | Atomic add request |
| add_sel | input | 1 | 0 = handed-tile counter, 1 = released-tile counter |
| add_stream | input | 6 | Target stream |
| add_amount | input | 32 | Amount to add |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x03 = clear counters) |
| cmd_count | input | 7 | Number of streams to clear |
| clr_busy | output | 1 | Bulk clear in progress |
| dispatch_pulse | output | 1 | One-cycle pulse after a dispatch write |

## Verification
The assertions assume that a request only counts when it is presented with `ready` high. They also assume that `cmd_valid` arriving during a clear is ignored rather than queued, so a `clr_busy` rise always traces back to a command in the previous cycle. The stimulus issues its probe request during a clear only to observe that the request is refused. Otherwise it waits for `clr_busy` to fall before it drives the bus or the add port again. All bus requests are held for exactly one cycle, so each read response is matched to a single request.

// File: rtl/strm_pkg.sv
package strm_pkg;
  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_RELEASED,
    HIT_HANDED,
    HIT_SYNC,
    HIT_DISPATCH
  } hit_e;
endpackage

// File: rtl/strm_addr_decode.sv
module strm_addr_decode
  import strm_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_STREAMS  = 64,
  parameter int STRIDE_LOG2  = 12,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFB4_0000,
  parameter int RELEASED_IDX = 8,
  parameter int HANDED_IDX   = 10,
  parameter int SYNC_STREAM  = 0,
  parameter int SYNC_IDX     = 31,
  parameter int DISP_STREAM  = 48,
  parameter int DISP_IDX     = 270,
  localparam int SID_W       = $clog2(NUM_STREAMS)
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [SID_W-1:0]  sid
);
  localparam int WIN_LOG2 = STRIDE_LOG2 + SID_W;
  localparam int RIDX_W   = STRIDE_LOG2 - 2;

  logic              in_win;
  logic [RIDX_W-1:0] ridx;

  always_comb begin
    in_win = (addr[ADDR_W-1:WIN_LOG2] == BASE[ADDR_W-1:WIN_LOG2]) && (addr[1:0] == 2'b00);
    sid    = addr[WIN_LOG2-1:STRIDE_LOG2];
    ridx   = addr[STRIDE_LOG2-1:2];
    hit    = HIT_NONE;
    if (in_win) begin
      if (ridx == RIDX_W'(RELEASED_IDX))
        hit = HIT_RELEASED;
      else if (ridx == RIDX_W'(HANDED_IDX))
        hit = HIT_HANDED;
      else if (ridx == RIDX_W'(SYNC_IDX) && sid == SID_W'(SYNC_STREAM))
        hit = HIT_SYNC;
      else if (ridx == RIDX_W'(DISP_IDX) && sid == SID_W'(DISP_STREAM))
        hit = HIT_DISPATCH;
    end
  end
endmodule

// File: rtl/strm_ctr_bank.sv
module strm_ctr_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              add_en,
  input  logic [IDX_W-1:0]  add_idx,
  input  logic [DATA_W-1:0] add_amt,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_keep;

  // The add wins over a bus write to the same counter.
  assign wr_keep = wr_en && !(add_en && add_idx == wr_idx);
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_keep) mem[wr_idx]  <= wr_data;
      if (add_en)  mem[add_idx] <= mem[add_idx] + add_amt;
      if (clr_en)  mem[clr_idx] <= '0;
    end
  end

  a_r9_add_beats_write: assert property (@(posedge clk) disable iff (rst)
    (add_en && wr_en && add_idx == wr_idx && !clr_en)
      |=> mem[$past(add_idx)] == $past(mem[add_idx]) + $past(add_amt));

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> mem[$past(clr_idx)] == '0);
endmodule

// File: rtl/strm_clear_seq.sv
module strm_clear_seq #(
  parameter int NUM_STREAMS = 64,
  parameter int CODE_W      = 8,
  parameter logic [CODE_W-1:0] INIT_CODE = 8'h03,
  localparam int SID_W      = $clog2(NUM_STREAMS),
  localparam int CNT_W      = $clog2(NUM_STREAMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              busy,
  output logic              clr_en,
  output logic [SID_W-1:0]  clr_idx
);
  logic [CNT_W-1:0] n_eff;
  logic [SID_W-1:0] idx_q, last_q;
  logic             start;

  always_comb begin
    n_eff = (cmd_count > CNT_W'(NUM_STREAMS)) ? CNT_W'(NUM_STREAMS) : cmd_count;
    start = cmd_valid && cmd_code == INIT_CODE && n_eff != '0;
  end

  assign clr_en  = busy;
  assign clr_idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        idx_q  <= '0;
        last_q <= SID_W'(n_eff - 1'b1);
      end
    end else if (idx_q == last_q) begin
      busy <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  a_r11_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> idx_q <= last_q);

  a_r10_start_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_code == INIT_CODE));
endmodule

// File: rtl/strm_regfile.sv
module strm_regfile
  import strm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_STREAMS = 64,
  parameter int STRIDE_LOG2 = 12,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFB4_0000,
  parameter int CODE_W      = 8,
  parameter logic [CODE_W-1:0] INIT_CODE = 8'h03,
  localparam int SID_W      = $clog2(NUM_STREAMS),
  localparam int CNT_W      = $clog2(NUM_STREAMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              add_valid,
  input  logic              add_sel,
  input  logic [SID_W-1:0]  add_stream,
  input  logic [DATA_W-1:0] add_amount,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              clr_busy,
  output logic              dispatch_pulse
);
  hit_e              hit;
  logic [SID_W-1:0]  sid;
  logic              wr_acc, rd_acc, add_acc;
  logic              clr_en;
  logic [SID_W-1:0]  clr_idx;
  logic [DATA_W-1:0] bank_rd [2];
  logic [DATA_W-1:0] sync_q;
  logic [DATA_W-1:0] rd_mux;

  assign ready   = !clr_busy;
  assign wr_acc  = bus_valid && ready && bus_write;
  assign rd_acc  = bus_valid && ready && !bus_write;
  assign add_acc = add_valid && ready;

  strm_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS), .STRIDE_LOG2(STRIDE_LOG2), .BASE(BASE)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .sid(sid)
  );

  strm_clear_seq #(
    .NUM_STREAMS(NUM_STREAMS), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE)
  ) u_clr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_count(cmd_count), .busy(clr_busy), .clr_en(clr_en), .clr_idx(clr_idx)
  );

  // Bank 0 counts handed tiles (add_sel 0), bank 1 counts released tiles (add_sel 1).
  for (genvar k = 0; k < 2; k++) begin : g_bank
    localparam hit_e KIND = (k == 0) ? HIT_HANDED : HIT_RELEASED;
    strm_ctr_bank #(.DATA_W(DATA_W), .DEPTH(NUM_STREAMS)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_acc && hit == KIND), .wr_idx(sid), .wr_data(bus_wdata),
      .add_en(add_acc && add_sel == 1'(k)), .add_idx(add_stream), .add_amt(add_amount),
      .clr_en(clr_en), .clr_idx(clr_idx),
      .rd_idx(sid), .rd_data(bank_rd[k])
    );
  end

  always_comb begin
    case (hit)
      HIT_HANDED:   rd_mux = bank_rd[0];
      HIT_RELEASED: rd_mux = bank_rd[1];
      HIT_SYNC:     rd_mux = sync_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q         <= '0;
      rd_valid       <= 1'b0;
      rd_data        <= '0;
      dispatch_pulse <= 1'b0;
    end else begin
      if (wr_acc && hit == HIT_SYNC) sync_q <= bus_wdata;
      rd_valid       <= rd_acc;
      if (rd_acc) rd_data <= rd_mux;
      dispatch_pulse <= wr_acc && hit == HIT_DISPATCH;
    end
  end

  a_r2_read_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_write && !clr_busy));

  a_r6_pulse_from_write: assert property (@(posedge clk) disable iff (rst)
    dispatch_pulse |-> $past(bus_valid && bus_write && !clr_busy && hit == HIT_DISPATCH));

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(hit == HIT_NONE || hit == HIT_DISPATCH)) |-> rd_data == '0);

  a_r11_no_read_while_busy: assert property (@(posedge clk) disable iff (rst)
    $past(clr_busy) |-> !rd_valid);
endmodule

// File: tb/sim_strm_regfile.sv
module sim_strm_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 0, bus_write = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic        ready, rd_valid, clr_busy, dispatch_pulse;
  logic [31:0] rd_data;
  logic        add_valid = 0, add_sel = 0;
  logic [5:0]  add_stream = 0;
  logic [31:0] add_amount = 0;
  logic        cmd_valid = 0;
  logic [7:0]  cmd_code = 0;
  logic [6:0]  cmd_count = 0;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] e_rel [64];
  logic [31:0] e_hnd [64];
  logic [31:0] e_sync;

  always #4 clk = ~clk;

  strm_regfile u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .add_valid(add_valid), .add_sel(add_sel), .add_stream(add_stream),
    .add_amount(add_amount), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_count(cmd_count), .clr_busy(clr_busy), .dispatch_pulse(dispatch_pulse)
  );

  function automatic logic [31:0] ra(input int s, input int r);
    return 32'hFFB4_0000 + 32'(s) * 32'h1000 + 32'(r) * 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk(tag, rd_data, exp);
  endtask

  task automatic add(input logic sel, input int s, input logic [31:0] amt);
    add_valid = 1; add_sel = sel; add_stream = 6'(s); add_amount = amt;
    @(negedge clk);
    add_valid = 0;
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 64; s++) begin
      rd_chk($sformatf("R3 %s released s%0d", tag, s), ra(s, 8), e_rel[s]);
      rd_chk($sformatf("R4 %s handed s%0d", tag, s), ra(s, 10), e_hnd[s]);
    end
    rd_chk({"R5 ", tag, " sync"}, ra(0, 31), e_sync);
  endtask

  task automatic clear_run(input logic [7:0] code, input int n, input int exp_cycles);
    int cyc = 0;
    cmd_valid = 1; cmd_code = code; cmd_count = 7'(n);
    @(negedge clk);
    cmd_valid = 0;
    while (clr_busy && cyc < 200) begin
      chk("R11 ready low while busy", 32'(ready), 32'd0);
      if (cyc == 0) begin
        bus_valid = 1; bus_write = 0; bus_addr = ra(0, 8);
        add_valid = 1; add_sel = 1; add_stream = 6'd63; add_amount = 32'd1000;
      end else begin
        bus_valid = 0; add_valid = 0;
      end
      cyc++;
      @(negedge clk);
      if (cyc == 1) chk("R11 held read not answered", 32'(rd_valid), 32'd0);
    end
    bus_valid = 0; add_valid = 0;
    chk($sformatf("R11 busy cycles code %0h n %0d", code, n), 32'(cyc), 32'(exp_cycles));
    if (code == 8'h03)
      for (int s = 0; s < 64 && s < n; s++) begin
        e_rel[s] = 0; e_hnd[s] = 0;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin e_rel[s] = 0; e_hnd[s] = 0; end
    e_sync = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 clr_busy", 32'(clr_busy), 32'd0);
    chk("R1 dispatch_pulse", 32'(dispatch_pulse), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    sweep("R1 reset");

    // R3 R4 distinct values per stream
    for (int s = 0; s < 64; s++) begin
      e_rel[s] = 32'hA000_0000 + 32'(s) * 7;
      e_hnd[s] = 32'h5000_0000 ^ (32'(s) << 8);
      wr(ra(s, 8), e_rel[s]);
      wr(ra(s, 10), e_hnd[s]);
    end
    // R2 rd_valid drops after a single read
    rd_chk("R2 single read", ra(3, 8), e_rel[3]);
    @(negedge clk);
    chk("R2 rd_valid one cycle", 32'(rd_valid), 32'd0);

    // R5 sync register
    e_sync = 32'h1234_5678;
    wr(ra(0, 31), e_sync);
    rd_chk("R5 other stream idx31", ra(5, 31), 32'd0);
    sweep("R3 R4 R5 written");

    // R7 unmapped writes and reads
    wr(ra(3, 9), 32'hDEAD_0001);
    wr(ra(5, 31), 32'hDEAD_0002);
    wr(32'h0000_1020, 32'hDEAD_0003);
    wr(ra(47, 270), 32'hDEAD_0004);
    wr(ra(2, 8) + 1, 32'hDEAD_0005);
    wr(ra(0, 31) + 2, 32'hDEAD_0006);
    rd_chk("R7 idx9", ra(3, 9), 32'd0);
    rd_chk("R7 idx31 s5", ra(5, 31), 32'd0);
    rd_chk("R7 outside window", 32'h0000_1020, 32'd0);
    rd_chk("R7 idx270 s47", ra(47, 270), 32'd0);
    rd_chk("R7 misaligned", ra(2, 8) + 1, 32'd0);
    sweep("R7 after unmapped writes");

    // R6 dispatch pulse
    bus_valid = 1; bus_write = 1; bus_addr = 32'hFFB7_0438; bus_wdata = 32'h77;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    chk("R6 pulse high", 32'(dispatch_pulse), 32'd1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(dispatch_pulse), 32'd0);
    rd_chk("R6 dispatch reads zero", 32'hFFB7_0438, 32'd0);

    // R8 atomic adds
    for (int s = 0; s < 64; s++) begin
      add(1'b0, s, 32'(s + 1));
      e_hnd[s] = e_hnd[s] + 32'(s + 1);
      add(1'b1, s, 32'(2 * s + 3));
      e_rel[s] = e_rel[s] + 32'(2 * s + 3);
    end
    sweep("R8 after adds");
    wr(ra(9, 10), 32'hFFFF_FFF0);
    add(1'b0, 9, 32'h20);
    e_hnd[9] = 32'h10;
    rd_chk("R8 wrap", ra(9, 10), 32'h10);

    // R9 same counter: add wins
    bus_valid = 1; bus_write = 1; bus_addr = ra(5, 8); bus_wdata = 32'h0BAD_0BAD;
    add_valid = 1; add_sel = 1; add_stream = 6'd5; add_amount = 32'd100;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; add_valid = 0;
    e_rel[5] = e_rel[5] + 32'd100;
    rd_chk("R9 add beats write", ra(5, 8), e_rel[5]);
    // R9 different counters: both apply
    bus_valid = 1; bus_write = 1; bus_addr = ra(6, 10); bus_wdata = 32'h0000_CAFE;
    add_valid = 1; add_sel = 1; add_stream = 6'd6; add_amount = 32'd9;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; add_valid = 0;
    e_hnd[6] = 32'h0000_CAFE;
    e_rel[6] = e_rel[6] + 32'd9;
    rd_chk("R9 write applied", ra(6, 10), e_hnd[6]);
    rd_chk("R9 add applied", ra(6, 8), e_rel[6]);

    // R12 read concurrent with add returns old value
    bus_valid = 1; bus_write = 0; bus_addr = ra(7, 8);
    add_valid = 1; add_sel = 1; add_stream = 6'd7; add_amount = 32'd5;
    @(negedge clk);
    bus_valid = 0; add_valid = 0;
    chk("R12 old value", rd_data, e_rel[7]);
    e_rel[7] = e_rel[7] + 32'd5;
    rd_chk("R12 new value", ra(7, 8), e_rel[7]);

    // R10 R11 partial clear, other code, zero count, oversize count
    clear_run(8'h03, 20, 20);
    sweep("R10 partial clear");
    clear_run(8'h05, 40, 0);
    clear_run(8'h03, 0, 0);
    sweep("R10 ignored commands");
    clear_run(8'h03, 100, 64);
    sweep("R10 full clear");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule